// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits behind an HDLC deframer. It takes the stream of deframed packet bytes and passes on only the packets whose address field matches the local station address. Each input byte comes with markers for start of packet and end of packet. A separate pulse reports an aborted packet. The block looks at the address byte or bytes at the head of each packet and either forwards the whole packet, address included, or drops every byte of it. It then waits for the next start of packet. Flag handling, bit de-stuffing, CRC checking and byte storage all happen elsewhere.

Two address registers, an enable and a width select set up the filter. With the enable low, every packet passes unchanged. In short mode a single address byte is checked, and only its upper six bits take part in the compare. In long mode two address bytes are checked in order. A byte whose upper seven bits are all ones is a broadcast address and is accepted in any address position. The deframer delivers bytes with at least one idle cycle between input events: no two of `in_valid_i` or `in_abort_i` fall on adjacent cycles. The configuration is held steady while a packet is in progress.

Top module: `hdlc_addr_filter`

## Requirements
- R1: With `filt_en_i` low, every byte of a packet is forwarded on the clock edge that samples it, with its data, start marker and end marker unchanged.
- R2: In short mode (`two_byte_i` low), the start-of-packet byte matches when its bits 7:2 equal bits 7:2 of `addr1_i`. Bits 1:0 take no part in the compare.
- R3: In long mode (`two_byte_i` high), the first byte must equal all eight bits of `addr1_i` and the second byte must equal all eight bits of `addr2_i`.
- R4: An address byte whose bits 7:1 are all ones matches in any address position, in either mode. A byte with bit 1 clear does not count as broadcast.
- R5: When an address byte fails to match, no byte, start marker, end marker or abort pulse of that packet appears at the output.
- R6: In short mode a matching packet is forwarded whole, starting with its address byte, which carries `out_sop_o`. Each byte appears on the edge that samples it.
- R7: In long mode the first address byte is held back. It appears, marked as start of packet, on the edge that samples a matching second byte. The second byte follows one cycle later, and later bytes appear on the edge that samples them.
- R8: A packet that ends or aborts before its address field is complete produces no output and no abort pulse.
- R9: An abort that arrives while a packet is being forwarded produces a one-cycle `out_abort_o` on the edge that samples it, with `out_valid_o` low. The packet's later bytes are then dropped.
- R10: Each start-of-packet byte starts a fresh address decision, whatever the outcome and progress of the previous packet.
- R11: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| filt_en_i | input | 1 | Address filtering enable |
| two_byte_i | input | 1 | 1: two-byte address field, 0: one-byte |
| addr1_i | input | 8 | First station address byte |
| addr2_i | input | 8 | Second station address byte |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_sop_i | input | 1 | Input byte is first of packet |
| in_eop_i | input | 1 | Input byte is last of packet |
| in_abort_i | input | 1 | Current packet aborted (no byte) |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_sop_o | output | 1 | Output byte is first of packet |
| out_eop_o | output | 1 | Output byte is last of packet |
| out_abort_o | output | 1 | Forwarded packet aborted |

## Verification
Every output is a register, so a byte passed straight through appears in the cycle after the edge that samples it. In long mode the held first byte is stamped with the sampling edge of the second byte, and the second byte is stamped one edge later. The bench counts clock edges and stamps each input byte with its sampling edge and each captured output byte with the edge that produced it. The latency checks compare these stamps: an offset of zero for straight-through bytes, and zero then one for the held pair. Dropped packets are checked by running the pipeline dry for several idle cycles and then confirming that nothing was captured, not even an abort pulse.

// File: rtl/haf_pkg.sv
package haf_pkg;
  typedef enum logic [1:0] {
    ST_DROP = 2'd0,  // waiting for next start of packet
    ST_ADR2 = 2'd1,  // first address byte held, second pending
    ST_PASS = 2'd2   // packet accepted, forwarding
  } haf_state_e;
endpackage

// File: rtl/haf_match.sv
module haf_match #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CMP_BITS  = 6,
  parameter int unsigned CALL_BITS = 7,
  parameter bit          CALL_EN   = 1'b1
) (
  input  logic              two_byte_i,
  input  logic [DATA_W-1:0] addr1_i,
  input  logic [DATA_W-1:0] addr2_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              first_ok_o,
  output logic              second_ok_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic short_hit, full1_hit, full2_hit, bcast;

  assign short_hit = (data_i[MSB -: CMP_BITS] == addr1_i[MSB -: CMP_BITS]);
  assign full1_hit = (data_i == addr1_i);
  assign full2_hit = (data_i == addr2_i);

  generate
    if (CALL_EN) begin : g_call
      assign bcast = &data_i[MSB -: CALL_BITS];
    end else begin : g_nocall
      assign bcast = 1'b0;
    end
  endgenerate

  assign first_ok_o  = bcast | (two_byte_i ? full1_hit : short_hit);
  assign second_ok_o = bcast | full2_hit;
endmodule

// File: rtl/haf_fsm.sv
module haf_fsm
  import haf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              two_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic              in_abort_i,
  input  logic              first_ok_i,
  input  logic              second_ok_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic              out_abort_o
);
  haf_state_e        st_q, st_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [DATA_W-1:0] pend_q, pend_d;
  logic              pend_v_q, pend_v_d;
  logic              pend_eop_q, pend_eop_d;
  logic              ov_d, osop_d, oeop_d, oab_d;
  logic [DATA_W-1:0] od_d;
  logic              pass_now;

  // start byte forwarded at once: filter off, or short-mode hit
  assign pass_now = !en_i || (!two_i && first_ok_i);

  always_comb begin
    st_d       = st_q;
    hold_d     = hold_q;
    pend_d     = pend_q;
    pend_v_d   = 1'b0;
    pend_eop_d = pend_eop_q;
    ov_d       = 1'b0;
    od_d       = out_data_o;
    osop_d     = 1'b0;
    oeop_d     = 1'b0;
    oab_d      = 1'b0;

    if (pend_v_q) begin
      ov_d   = 1'b1;
      od_d   = pend_q;
      oeop_d = pend_eop_q;
    end

    if (in_valid_i) begin
      if (in_sop_i) begin
        if (pass_now) begin
          ov_d   = 1'b1;
          od_d   = in_data_i;
          osop_d = 1'b1;
          oeop_d = in_eop_i;
          st_d   = in_eop_i ? ST_DROP : ST_PASS;
        end else if (first_ok_i && !in_eop_i) begin
          hold_d = in_data_i;
          st_d   = ST_ADR2;
        end else begin
          st_d = ST_DROP;
        end
      end else begin
        unique case (st_q)
          ST_PASS: begin
            ov_d   = 1'b1;
            od_d   = in_data_i;
            oeop_d = in_eop_i;
            if (in_eop_i) st_d = ST_DROP;
          end
          ST_ADR2: begin
            if (second_ok_i) begin
              ov_d       = 1'b1;
              od_d       = hold_q;
              osop_d     = 1'b1;
              pend_v_d   = 1'b1;
              pend_d     = in_data_i;
              pend_eop_d = in_eop_i;
              st_d       = in_eop_i ? ST_DROP : ST_PASS;
            end else begin
              st_d = ST_DROP;
            end
          end
          default: ;
        endcase
      end
    end else if (in_abort_i) begin
      oab_d = (st_q == ST_PASS);
      st_d  = ST_DROP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_DROP;
      hold_q      <= '0;
      pend_q      <= '0;
      pend_v_q    <= 1'b0;
      pend_eop_q  <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
      out_abort_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      hold_q      <= hold_d;
      pend_q      <= pend_d;
      pend_v_q    <= pend_v_d;
      pend_eop_q  <= pend_eop_d;
      out_valid_o <= ov_d;
      out_data_o  <= od_d;
      out_sop_o   <= osop_d;
      out_eop_o   <= oeop_d;
      out_abort_o <= oab_d;
    end
  end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CMP_BITS  = 6,
  parameter int unsigned CALL_BITS = 7,
  parameter bit          CALL_EN   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              filt_en_i,
  input  logic              two_byte_i,
  input  logic [DATA_W-1:0] addr1_i,
  input  logic [DATA_W-1:0] addr2_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic              in_abort_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic              out_abort_o
);
  logic first_ok, second_ok;

  haf_match #(
    .DATA_W   (DATA_W),
    .CMP_BITS (CMP_BITS),
    .CALL_BITS(CALL_BITS),
    .CALL_EN  (CALL_EN)
  ) u_match (
    .two_byte_i (two_byte_i),
    .addr1_i    (addr1_i),
    .addr2_i    (addr2_i),
    .data_i     (in_data_i),
    .first_ok_o (first_ok),
    .second_ok_o(second_ok)
  );

  haf_fsm #(
    .DATA_W(DATA_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (filt_en_i),
    .two_i      (two_byte_i),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_sop_i   (in_sop_i),
    .in_eop_i   (in_eop_i),
    .in_abort_i (in_abort_i),
    .first_ok_i (first_ok),
    .second_ok_i(second_ok),
    .out_valid_o(out_valid_o),
    .out_data_o (out_data_o),
    .out_sop_o  (out_sop_o),
    .out_eop_o  (out_eop_o),
    .out_abort_o(out_abort_o)
  );
endmodule

// File: rtl/haf_checker.sv
module haf_checker #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CMP_BITS  = 6,
  parameter int unsigned CALL_BITS = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              filt_en_i,
  input logic              two_byte_i,
  input logic [DATA_W-1:0] addr1_i,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              in_sop_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_sop_o,
  input logic              out_abort_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic start_byte, is_call, short_eq;
  assign start_byte = in_valid_i && in_sop_i;
  assign is_call    = &in_data_i[MSB -: CALL_BITS];
  assign short_eq   = (in_data_i[MSB -: CMP_BITS] == addr1_i[MSB -: CMP_BITS]);

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!out_valid_o && !out_abort_o); // R11
    end
  end

  AST_BYPASS_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_byte && !filt_en_i |=> out_valid_o && out_sop_o && out_data_o == $past(in_data_i)); // R1

  AST_SHORT_MISS_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_byte && filt_en_i && !two_byte_i && !short_eq && !is_call |=> !out_valid_o); // R5

  AST_CALL_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_byte && filt_en_i && !two_byte_i && is_call |=> out_valid_o && out_sop_o); // R4

  AST_LONG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_byte && filt_en_i && two_byte_i |=> !out_valid_o); // R7

  AST_ABORT_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_abort_o |-> !out_valid_o); // R9
endmodule

bind hdlc_addr_filter haf_checker #(
  .DATA_W   (DATA_W),
  .CMP_BITS (CMP_BITS),
  .CALL_BITS(CALL_BITS)
) u_haf_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .filt_en_i  (filt_en_i),
  .two_byte_i (two_byte_i),
  .addr1_i    (addr1_i),
  .in_valid_i (in_valid_i),
  .in_data_i  (in_data_i),
  .in_sop_i   (in_sop_i),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .out_sop_o  (out_sop_o),
  .out_abort_o(out_abort_o)
);

// File: tb/hdlc_addr_filter_tb.sv
module hdlc_addr_filter_tb_top;
  localparam int CLK_P = 10;
  localparam int CAP_N = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, two = 1'b0;
  logic [7:0] a1 = 8'h00, a2 = 8'h00;
  logic       iv = 1'b0, isop = 1'b0, ieop = 1'b0, iab = 1'b0;
  logic [7:0] id = 8'h00;
  logic       ov, osop, oeop, oab;
  logic [7:0] od;

  int checks = 0, errors = 0;
  int cyc = 0;
  int t_in = 0;
  int cap_n = 0, ab_n = 0;
  logic [7:0] cap_d [CAP_N];
  logic       cap_s [CAP_N];
  logic       cap_e [CAP_N];
  int         cap_t [CAP_N];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hdlc_addr_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .filt_en_i(en), .two_byte_i(two),
    .addr1_i(a1), .addr2_i(a2), .in_valid_i(iv), .in_data_i(id),
    .in_sop_i(isop), .in_eop_i(ieop), .in_abort_i(iab),
    .out_valid_o(ov), .out_data_o(od), .out_sop_o(osop),
    .out_eop_o(oeop), .out_abort_o(oab)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (ov && cap_n < CAP_N) begin
        cap_d[cap_n] = od; cap_s[cap_n] = osop;
        cap_e[cap_n] = oeop; cap_t[cap_n] = cyc;
        cap_n = cap_n + 1;
      end
      if (oab) ab_n = ab_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    cap_n = 0; ab_n = 0;
  endtask

  task automatic put(input logic [7:0] d, input logic s, input logic e);
    iv = 1'b1; id = d; isop = s; ieop = e;
    @(negedge clk);
    t_in = cyc;
    iv = 1'b0; isop = 1'b0; ieop = 1'b0;
    @(negedge clk);
  endtask

  task automatic abort_pkt();
    iab = 1'b1;
    @(negedge clk);
    iab = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_byte(input int i, input logic [7:0] d, input logic s, input logic e, input string req);
    chk(cap_n > i, req, cap_n, i + 1);
    if (cap_n > i) chk(cap_d[i] == d && cap_s[i] == s && cap_e[i] == e, req,
                       {cap_d[i], 3'b0, cap_s[i], 3'b0, cap_e[i]}, {d, 3'b0, s, 3'b0, e});
  endtask

  task automatic t_reset();
    chk(!ov && !oab && !osop && !oeop, "R11 reset outputs", {ov, oab, osop, oeop}, 0);
  endtask

  task automatic t_bypass();
    int t0;
    en = 1'b0; two = 1'b0; a1 = 8'h00; clr();
    put(8'h5C, 1, 0); t0 = t_in;
    put(8'h01, 0, 0);
    put(8'h02, 0, 1);
    drain();
    chk(cap_n == 3, "R1 bypass count", cap_n, 3);
    chk_byte(0, 8'h5C, 1, 0, "R1 bypass first");
    chk_byte(2, 8'h02, 0, 1, "R1 bypass last");
    if (cap_n > 0) chk(cap_t[0] == t0, "R1 bypass latency", cap_t[0], t0);
  endtask

  task automatic t_short_hit();
    int t0;
    en = 1'b1; two = 1'b0; a1 = 8'hA8; clr();
    put(8'hAB, 1, 0); t0 = t_in;   // R2: bits 1:0 differ, ignored
    put(8'h33, 0, 0);
    put(8'h44, 0, 1);
    drain();
    chk(cap_n == 3, "R2 short hit count", cap_n, 3);
    chk_byte(0, 8'hAB, 1, 0, "R6 address byte forwarded");
    chk_byte(1, 8'h33, 0, 0, "R6 middle byte");
    chk_byte(2, 8'h44, 0, 1, "R6 last byte");
    if (cap_n > 0) chk(cap_t[0] == t0, "R6 latency", cap_t[0], t0);
  endtask

  task automatic t_short_miss();
    en = 1'b1; two = 1'b0; a1 = 8'hA8; clr();
    put(8'hB8, 1, 0);              // bit 4 differs
    put(8'h11, 0, 0);
    abort_pkt();
    put(8'hFC, 1, 0);              // R4 boundary: not broadcast
    put(8'h22, 0, 1);
    drain();
    chk(cap_n == 0, "R5 short miss no bytes", cap_n, 0);
    chk(ab_n == 0, "R5 short miss no abort", ab_n, 0);
  endtask

  task automatic t_short_call();
    en = 1'b1; two = 1'b0; a1 = 8'hA8; clr();
    put(8'hFE, 1, 0);
    put(8'h55, 0, 1);
    put(8'hFF, 1, 1);
    drain();
    chk(cap_n == 3, "R4 broadcast short count", cap_n, 3);
    chk_byte(0, 8'hFE, 1, 0, "R4 broadcast FE");
    chk_byte(2, 8'hFF, 1, 1, "R4 broadcast FF");
  endtask

  task automatic t_long_hit();
    int t1, t2;
    en = 1'b1; two = 1'b1; a1 = 8'h3C; a2 = 8'h5A; clr();
    put(8'h3C, 1, 0);
    put(8'h5A, 0, 0); t1 = t_in;
    put(8'h11, 0, 0); t2 = t_in;
    put(8'h22, 0, 1);
    drain();
    chk(cap_n == 4, "R3 long hit count", cap_n, 4);
    chk_byte(0, 8'h3C, 1, 0, "R7 held first byte");
    chk_byte(1, 8'h5A, 0, 0, "R7 second byte");
    chk_byte(3, 8'h22, 0, 1, "R3 last byte");
    if (cap_n > 2) begin
      chk(cap_t[0] == t1, "R7 held byte timing", cap_t[0], t1);
      chk(cap_t[1] == t1 + 1, "R7 second byte timing", cap_t[1], t1 + 1);
      chk(cap_t[2] == t2, "R7 payload timing", cap_t[2], t2);
    end
  endtask

  task automatic t_long_miss();
    en = 1'b1; two = 1'b1; a1 = 8'h3C; a2 = 8'h5A; clr();
    put(8'h3D, 1, 0);              // R3: first byte full compare
    put(8'h5A, 0, 0);
    put(8'h01, 0, 1);
    put(8'h3C, 1, 0);
    put(8'h5B, 0, 0);              // second byte miss
    put(8'h02, 0, 1);
    drain();
    chk(cap_n == 0, "R5 long miss no bytes", cap_n, 0);
  endtask

  task automatic t_long_call();
    en = 1'b1; two = 1'b1; a1 = 8'h3C; a2 = 8'h5A; clr();
    put(8'h3C, 1, 0);
    put(8'hFF, 0, 0);
    put(8'h77, 0, 1);
    drain();
    chk(cap_n == 3, "R4 broadcast second count", cap_n, 3);
    chk_byte(2, 8'h77, 0, 1, "R4 broadcast second payload");
  endtask

  task automatic t_early_end();
    en = 1'b1; two = 1'b1; a1 = 8'h3C; a2 = 8'h5A; clr();
    put(8'h3C, 1, 1);              // ends after one address byte
    put(8'h3C, 1, 0);
    abort_pkt();                   // aborts after one address byte
    put(8'h5A, 0, 0);              // stray byte, no packet open
    drain();
    chk(cap_n == 0, "R8 early end no bytes", cap_n, 0);
    chk(ab_n == 0, "R8 early abort silent", ab_n, 0);
  endtask

  task automatic t_abort_fwd();
    en = 1'b1; two = 1'b0; a1 = 8'hA8; clr();
    put(8'hA8, 1, 0);
    put(8'h10, 0, 0);
    abort_pkt();
    put(8'h20, 0, 1);              // after abort: dropped
    drain();
    chk(ab_n == 1, "R9 abort pulse", ab_n, 1);
    chk(cap_n == 2, "R9 bytes after abort dropped", cap_n, 2);
  endtask

  task automatic t_restart();
    en = 1'b1; two = 1'b0; a1 = 8'hA8; clr();
    put(8'h00, 1, 0);              // rejected, left open
    put(8'hA9, 1, 0);              // new decision: hit
    put(8'h66, 0, 0);
    put(8'h04, 1, 0);              // new start mid-packet: miss
    put(8'h99, 0, 1);
    drain();
    chk(cap_n == 2, "R10 restart count", cap_n, 2);
    chk_byte(0, 8'hA9, 1, 0, "R10 accepted after reject");
    chk_byte(1, 8'h66, 0, 0, "R10 payload");
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_bypass();
    t_short_hit();
    t_short_miss();
    t_short_call();
    t_long_hit();
    t_long_miss();
    t_long_call();
    t_early_end();
    t_abort_fwd();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule